// File: doc/BRIEF.md
# Pipelined-Address Bus Cycle Controller

This block is the bus-state sequencer of a simple processor-style bus master. It takes one internal transfer request at a time (an address and a read/write flag) and runs a bus cycle for it. Each cycle has an address state, in which an address strobe is raised, and one or more data states. A data state ends when the acknowledge input is seen. Every rising clock edge moves the controller forward by exactly one bus state.

While the current cycle is still in its data phase and has not yet been acknowledged, an external agent can raise the early-address input. The controller then puts the next pending request's address on the bus ahead of time, so that address and data phases overlap. This is decided again for every cycle. The input is only looked at in unacknowledged data states, and it counts at most once per cycle. After any idle state the bus always falls back to the plain, non-overlapped cycle form.

An external master can ask for the bus through a hold request. The controller grants it at a cycle boundary, raises a hold-acknowledge output and keeps its address outputs quiet until the request is dropped.

Top module: `bus_pipe_ctrl`

## Requirements
- R1: While rst_n is low and right after it rises, bus_state reads 0 (idle), addr_strobe, hold_ack and req_take are low, and bus_addr and bus_write are 0.
- R2: bus_state encodes idle=0, address=1, data=2, overlap=3, pending=4, armed=5, hold=6. An address state is always followed by a data state. From idle, a request with no hold goes to the address state, so the first cycle after idle is never overlapped.
- R3: In a data state with rdy low and nxt_addr low, the controller stays in the data state (wait state).
- R4: In a data or armed state with rdy high, the next state is hold if hold_req is high, otherwise address if req_valid is high, otherwise idle.
- R5: In a data state with rdy low and nxt_addr high, the controller moves to overlap if req_valid is high, otherwise to armed.
- R6: nxt_addr has no effect in the address, armed, overlap and pending states.
- R7: In the armed state with rdy low, a request (req_valid high) moves the controller to overlap. With no request it stays armed.
- R8: In overlap or pending with rdy low, the next state is pending. With rdy high, the next state is data, and the early-issued request becomes the current cycle without a new address state.
- R9: addr_strobe is high only in the address and overlap states. bus_addr and bus_write show the current cycle in the address, data and armed states, the early-issued request in the overlap and pending states, and 0 in idle and hold.
- R10: In idle, hold_req wins over a request. hold_ack is high exactly in the hold state. The hold state is left when hold_req is low, going to address if req_valid is high, otherwise to idle.
- R11: req_take is high exactly in the bus state whose next state is address or overlap reached through a new request. The request's address and write flag are captured at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one rising edge per bus state |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Internal transfer request pending |
| req_addr | input | AW | Address of the pending request |
| req_write | input | 1 | 1 = write, 0 = read for the pending request |
| req_take | output | 1 | Request is captured at the coming edge |
| rdy | input | 1 | Current cycle acknowledged |
| nxt_addr | input | 1 | Early-address request for the next cycle |
| hold_req | input | 1 | External master asks for the bus |
| hold_ack | output | 1 | Bus granted to the external master |
| addr_strobe | output | 1 | Address strobe, new address on the bus |
| bus_addr | output | AW | Address driven on the bus |
| bus_write | output | 1 | Cycle definition: 1 = write |
| bus_state | output | 3 | Current bus state code |

## Verification
The bench goes after the early-address window. It raises nxt_addr in the address state and in a data state that is acknowledged at once. A design that sampled it too early would overlap cycles that have no wait state. It also repeats nxt_addr in the armed and pending states, where a design without the once-per-cycle rule would issue a second early address. A request that arrives late while armed must still be overlapped, and an acknowledge in overlap or pending must hand the early address straight to a data state. A design that inserted a new address state there, or lost the captured address, shows the wrong bus_state or bus_addr. Hold priority over requests in idle, and quiet outputs during hold, are also checked against a random mix of all inputs.

// File: rtl/bus_pipe_pkg.sv
package bus_pipe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_DATA  = 3'd2,
    ST_OVLP  = 3'd3,
    ST_PEND  = 3'd4,
    ST_ARMED = 3'd5,
    ST_HOLD  = 3'd6
  } bus_st_e;

  // states in which an acknowledge completes the current cycle
  function automatic logic is_data_phase(bus_st_e s);
    return (s == ST_DATA) || (s == ST_ARMED) || (s == ST_OVLP) || (s == ST_PEND);
  endfunction

  // states that put a fresh address on the bus
  function automatic logic drives_strobe(bus_st_e s);
    return (s == ST_ADDR) || (s == ST_OVLP);
  endfunction

  // states whose bus address belongs to the early-issued request
  function automatic logic shows_next(bus_st_e s);
    return (s == ST_OVLP) || (s == ST_PEND);
  endfunction

  // states whose bus address belongs to the current cycle
  function automatic logic shows_cur(bus_st_e s);
    return (s == ST_ADDR) || (s == ST_DATA) || (s == ST_ARMED);
  endfunction

endpackage

// File: rtl/bpc_fsm.sv
module bpc_fsm
  import bus_pipe_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    rdy,
  input  logic    nxt_addr,
  input  logic    hold_req,
  output bus_st_e st_q,
  output logic    load_cur,
  output logic    load_nxt,
  output logic    promote
);

  bus_st_e st_d;

  // named internal events
  logic cyc_ack;      // current cycle acknowledged this bus state
  logic na_sampled;   // early-address request taken in a plain data state
  logic late_req;     // request arriving while armed

  assign cyc_ack    = is_data_phase(st_q) && rdy;
  assign na_sampled = (st_q == ST_DATA) && !rdy && nxt_addr;
  assign late_req   = (st_q == ST_ARMED) && !rdy && req_valid;

  always_comb begin
    st_d     = st_q;
    load_cur = 1'b0;
    load_nxt = 1'b0;
    promote  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (hold_req) begin
          st_d = ST_HOLD;
        end else if (req_valid) begin
          st_d     = ST_ADDR;
          load_cur = 1'b1;
        end
      end
      ST_ADDR: st_d = ST_DATA;
      ST_DATA, ST_ARMED: begin
        if (cyc_ack) begin
          if (hold_req) begin
            st_d = ST_HOLD;
          end else if (req_valid) begin
            st_d     = ST_ADDR;
            load_cur = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end else if ((na_sampled || late_req) && req_valid) begin
          st_d     = ST_OVLP;
          load_nxt = 1'b1;
        end else if (na_sampled) begin
          st_d = ST_ARMED;
        end
      end
      ST_OVLP, ST_PEND: begin
        if (cyc_ack) begin
          st_d    = ST_DATA;
          promote = 1'b1;
        end else begin
          st_d = ST_PEND;
        end
      end
      ST_HOLD: begin
        if (!hold_req) begin
          if (req_valid) begin
            st_d     = ST_ADDR;
            load_cur = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  AST_ADDR_THEN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_ADDR |=> st_q == ST_DATA); // R2

  AST_WAIT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DATA) && !rdy && !nxt_addr |=> st_q == ST_DATA); // R3

  AST_ACK_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_ack && !shows_next(st_q) && !hold_req && !req_valid |=> st_q == ST_IDLE); // R4

  AST_NA_NO_REQ_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    na_sampled && !req_valid |=> st_q == ST_ARMED); // R5

  AST_ARMED_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARMED) && !rdy && !req_valid |=> st_q == ST_ARMED); // R6

  AST_LATE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    late_req |=> st_q == ST_OVLP); // R7

  AST_PIPE_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    shows_next(st_q) && rdy |=> st_q == ST_DATA); // R8

  AST_HOLD_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) && hold_req |=> st_q == ST_HOLD); // R10

endmodule

// File: rtl/bpc_addr_regs.sv
module bpc_addr_regs
  import bus_pipe_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_st_e       st_q,
  input  logic          load_cur,
  input  logic          load_nxt,
  input  logic          promote,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  output logic [AW-1:0] bus_addr,
  output logic          bus_write
);

  localparam int SLOT_W = AW + 1;

  logic [SLOT_W-1:0] cur_q, nxt_q, req_slot;

  assign req_slot = {req_write, req_addr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      nxt_q <= '0;
    end else begin
      if (load_cur)     cur_q <= req_slot;
      else if (promote) cur_q <= nxt_q;
      if (load_nxt)     nxt_q <= req_slot;
    end
  end

  always_comb begin
    if (shows_next(st_q))      {bus_write, bus_addr} = nxt_q;
    else if (shows_cur(st_q))  {bus_write, bus_addr} = cur_q;
    else                       {bus_write, bus_addr} = '0;
  end

  AST_NO_DOUBLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_cur && (load_nxt || promote))); // R11

endmodule

// File: rtl/bus_pipe_ctrl.sv
module bus_pipe_ctrl
  import bus_pipe_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  output logic          req_take,
  input  logic          rdy,
  input  logic          nxt_addr,
  input  logic          hold_req,
  output logic          hold_ack,
  output logic          addr_strobe,
  output logic [AW-1:0] bus_addr,
  output logic          bus_write,
  output logic [2:0]    bus_state
);

  bus_st_e st_q;
  logic    load_cur, load_nxt, promote;

  bpc_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rdy       (rdy),
    .nxt_addr  (nxt_addr),
    .hold_req  (hold_req),
    .st_q      (st_q),
    .load_cur  (load_cur),
    .load_nxt  (load_nxt),
    .promote   (promote)
  );

  bpc_addr_regs #(.AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_q      (st_q),
    .load_cur  (load_cur),
    .load_nxt  (load_nxt),
    .promote   (promote),
    .req_addr  (req_addr),
    .req_write (req_write),
    .bus_addr  (bus_addr),
    .bus_write (bus_write)
  );

  assign req_take    = load_cur || load_nxt;
  assign hold_ack    = (st_q == ST_HOLD);
  assign addr_strobe = drives_strobe(st_q);
  assign bus_state   = st_q;

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> !addr_strobe && (bus_addr == '0) && !bus_write); // R10

  AST_TAKE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    req_take |=> addr_strobe); // R11

  AST_EARLY_ADDR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_state == 3'd3 || bus_state == 3'd4) && rdy |=>
      (bus_addr == $past(bus_addr)) && (bus_write == $past(bus_write))); // R8

  AST_STROBE_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |=> !addr_strobe); // R9

endmodule

// File: tb/bus_pipe_ctrl_tb_top.sv
`timescale 1ns/1ps
module bus_pipe_ctrl_tb_top;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic          rdy = 1'b0;
  logic          nxt_addr = 1'b0;
  logic          hold_req = 1'b0;
  logic          req_take, hold_ack, addr_strobe, bus_write;
  logic [AW-1:0] bus_addr;
  logic [2:0]    bus_state;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bus_pipe_ctrl #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_take(req_take), .rdy(rdy), .nxt_addr(nxt_addr),
    .hold_req(hold_req), .hold_ack(hold_ack), .addr_strobe(addr_strobe),
    .bus_addr(bus_addr), .bus_write(bus_write), .bus_state(bus_state)
  );

  // reference model state
  int            m_st = 0;
  logic [AW-1:0] m_cur_a = '0, m_nxt_a = '0;
  logic          m_cur_w = 1'b0, m_nxt_w = 1'b0;
  string         m_tag = "R1";

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // next bus state from the requirement table
  function automatic int ref_next(int s, bit rv, bit rd, bit na, bit ho);
    if (s == 0) return ho ? 6 : (rv ? 1 : 0);
    if (s == 1) return 2;
    if (s == 2 || s == 5) begin
      if (rd) return ho ? 6 : (rv ? 1 : 0);
      if (s == 2 && na) return rv ? 3 : 5;
      if (s == 5 && rv) return 3;
      return s;
    end
    if (s == 3 || s == 4) return rd ? 2 : 4;
    if (s == 6) return ho ? 6 : (rv ? 1 : 0);
    return 0;
  endfunction

  function automatic bit ref_take(int s, int n);
    return (n == 1 && s != 1) || (n == 3 && s != 3);
  endfunction

  function automatic string ref_tag(int s, bit rv, bit rd, bit na, bit ho);
    case (s)
      0: return ho ? "R10" : "R2";
      1: return na ? "R6" : "R2";
      2: return rd ? "R4" : (na ? "R5" : "R3");
      5: return rd ? "R4" : (rv ? "R7" : "R6");
      3, 4: return "R8";
      6: return "R10";
      default: return "R2";
    endcase
  endfunction

  // one bus state: drive, check, advance model
  task automatic step(bit rv, logic [AW-1:0] a, bit w, bit rd, bit na, bit ho, output bit took);
    int n;
    logic [AW-1:0] ea;
    bit ew;
    @(negedge clk);
    req_valid = rv; req_addr = a; req_write = w;
    rdy = rd; nxt_addr = na; hold_req = ho;
    #2;
    chk(m_tag, "bus_state", bus_state, m_st);
    ea = (m_st == 1 || m_st == 2 || m_st == 5) ? m_cur_a : ((m_st == 3 || m_st == 4) ? m_nxt_a : '0);
    ew = (m_st == 1 || m_st == 2 || m_st == 5) ? m_cur_w : ((m_st == 3 || m_st == 4) ? m_nxt_w : 1'b0);
    chk("R9", "addr_strobe", addr_strobe, (m_st == 1 || m_st == 3));
    chk("R9", "bus_addr", bus_addr, ea);
    chk("R9", "bus_write", bus_write, ew);
    chk("R10", "hold_ack", hold_ack, (m_st == 6));
    n = ref_next(m_st, rv, rd, na, ho);
    took = ref_take(m_st, n);
    chk("R11", "req_take", req_take, took);
    m_tag = ref_tag(m_st, rv, rd, na, ho);
    if ((m_st == 3 || m_st == 4) && rd) begin m_cur_a = m_nxt_a; m_cur_w = m_nxt_w; end
    if (n == 1 && took) begin m_cur_a = a; m_cur_w = w; end
    if (n == 3 && took) begin m_nxt_a = a; m_nxt_w = w; end
    m_st = n;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit t;
    bit rv = 0, wr = 0;
    logic [AW-1:0] ra = '0;
    int hold_cnt = 0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    #2;
    chk("R1", "reset bus_state", bus_state, 0);
    chk("R1", "reset strobe", addr_strobe, 0);
    chk("R1", "reset hold_ack", hold_ack, 0);
    chk("R1", "reset bus_addr", bus_addr, 0);
    chk("R1", "reset req_take", req_take, 0);
    @(negedge clk); rst_n = 1'b1;

    // directed corner cases
    step(1, 32'hAAAA_0001, 1, 0, 0, 1, t);  // hold wins over request in idle
    step(1, 32'hAAAA_0001, 1, 0, 0, 1, t);  // stay in hold
    step(1, 32'hAAAA_0001, 1, 0, 0, 0, t);  // hold drops, request taken
    step(0, '0, 0, 0, 1, 0, t);             // nxt_addr in address state ignored
    step(0, '0, 0, 0, 1, 0, t);             // sampled, nothing pending -> armed
    step(0, '0, 0, 0, 1, 0, t);             // armed: repeat ignored
    step(1, 32'hBBBB_0002, 0, 0, 0, 0, t);  // late request overlapped
    step(0, '0, 0, 0, 1, 0, t);             // overlap -> pending
    step(0, '0, 0, 1, 1, 0, t);             // ack: early request enters data
    step(0, '0, 0, 0, 0, 0, t);             // wait state
    step(1, 32'hCCCC_0003, 1, 1, 1, 0, t);  // ack with request, na ignored
    step(0, '0, 0, 0, 0, 0, t);             // address -> data
    step(1, 32'hDDDD_0004, 0, 0, 1, 0, t);  // na with request -> overlap
    step(0, '0, 0, 1, 0, 0, t);             // ack in overlap -> data
    step(0, '0, 0, 1, 0, 1, t);             // ack with hold -> hold
    step(0, '0, 0, 0, 0, 0, t);             // hold -> idle
    step(0, '0, 0, 0, 0, 0, t);             // idle stays

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      if (!rv && ($urandom % 100) < 55) begin
        rv = 1; ra = $urandom; wr = $urandom % 2;
      end
      if (hold_cnt > 0) hold_cnt--;
      else if (($urandom % 100) < 3) hold_cnt = 1 + $urandom % 5;
      step(rv, rv ? ra : '0, rv ? wr : 1'b0, ($urandom % 100) < 40,
           ($urandom % 100) < 45, hold_cnt > 0, t);
      if (t) rv = 0;
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule